// File: doc/BRIEF.md
# Base-Limit Memory Protection Checker

This block decides, for every memory request, whether the access may proceed. It holds a small set of protection regions, each described by an inclusive lower and upper address bound on a 32-byte grain, plus a two-bit access-permission code and an execute-never flag. Software programs the regions through a single-word write port that selects one region and either its lower-bound word or its upper-bound word.

A request carries an address, an access kind (read, write or instruction fetch) and a privilege flag. Some requests skip the region search entirely and are treated as hits on a default map: when protection is switched off, when the address is inside the private peripheral window, or when the default map is switched on and the request is privileged. Otherwise every enabled region is compared in parallel. A single matching region supplies the permissions. No match gives a background fault. Two or more matches always give a permission fault; no region takes priority over another. The verdict, a fault status code and the granted read/write/execute bits are registered and appear on the cycle after the request.

Top module: `bl_prot_check`

## Requirements
- R1: A region's lower bound is bits [31:5] of its lower-bound word with bits [4:0] taken as zero, and its upper bound is bits [31:5] of its upper-bound word with bits [4:0] taken as one; both bounds are inclusive. cfg_sel = 0 writes the lower-bound word and cfg_sel = 1 the upper-bound word of region cfg_idx.
- R2: Bit 0 of a region's upper-bound word enables it; a region with that bit clear matches no address.
- R3: In the lower-bound word, bits [2:1] hold the permission code and bit 0 the execute-never flag. Code 00 grants read and write to privileged requests only, 01 read and write to all, 10 read only to privileged requests only, 11 read only to all.
- R4: When the search runs and two or more enabled regions contain the address, the access faults with status 0x0D and all permission outputs are 0.
- R5: When the search runs and no enabled region contains the address, the access faults with status 0x00 and all permission outputs are 0.
- R6: The search is skipped and the default map applies when mpu_on is 0, when the address is in 0xE0000000 to 0xE00FFFFF, or when bg_map_on is 1 and req_priv is 1; the default map grants read and write, and execute only below 0xE0000000.
- R7: Any address at or above 0xE0000000 never gets execute permission, whatever the region's execute-never flag.
- R8: Execute permission is granted only when read or write is granted and execute-never is clear.
- R9: req_kind 00 is a read and needs read permission, 01 a write needing write permission, 10 a fetch needing execute permission, and 11 is never permitted; a hit whose kind is not permitted faults with status 0x0D and still reports the granted permission bits. A permitted access reports status 0x00.
- R10: rsp_valid is high exactly on the cycle after a cycle with req_valid high; the verdict, status and permission outputs hold their values while no request arrives. A request sees the region set as it stood before any write made in the same cycle.
- R11: After reset every region is disabled and all response outputs are 0; rsp_fault is the complement of rsp_allow whenever rsp_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cfg_we | input | 1 | Region word write strobe |
| cfg_idx | input | 3 | Region number to write |
| cfg_sel | input | 1 | 0 selects the lower-bound word, 1 the upper-bound word |
| cfg_wdata | input | 32 | Word to write |
| mpu_on | input | 1 | Protection enable; 0 lets every access use the default map |
| bg_map_on | input | 1 | Default map enable for privileged requests |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 reserved |
| req_priv | input | 1 | 1 for a privileged request |
| rsp_valid | output | 1 | Verdict for the previous cycle's request |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 1 | Access refused |
| rsp_status | output | 8 | Fault status: 0x0D permission, 0x00 background or none |
| rsp_perm_r | output | 1 | Read granted at this address |
| rsp_perm_w | output | 1 | Write granted at this address |
| rsp_perm_x | output | 1 | Execute granted at this address |

## Verification
Every verdict is due one clock edge after the request cycle and a region write becomes visible to requests one edge after the write cycle. The bench drives request and write inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge, so each check lands on the cycle the response register was loaded. The hold behaviour is checked one further cycle on, with no request driven, and the same-cycle write case drives a write and a request on the same falling edge to show the request saw the older region set.

// File: rtl/bl_prot_pkg.sv
package bl_prot_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_FX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_kind_e;

  localparam int FST_W = 8;
  localparam logic [FST_W-1:0] FST_OK   = 8'h00;
  localparam logic [FST_W-1:0] FST_BG   = 8'h00;
  localparam logic [FST_W-1:0] FST_PERM = 8'h0D;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

endpackage

// File: rtl/bl_region_file.sv
module bl_region_file #(
  parameter int NREG   = 8,
  parameter int AW     = 32,
  parameter int GB     = 5,
  parameter int ATTR_W = 3,
  parameter int IDX_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_sel,
  input  logic [AW-1:0]       cfg_wdata,
  output logic [AW-GB-1:0]    base_hi [NREG],
  output logic [ATTR_W-1:0]   attr    [NREG],
  output logic [AW-GB-1:0]    lim_hi  [NREG],
  output logic [NREG-1:0]     en
);

  localparam int HI_W = AW - GB;

  logic unused_wdata_mid;
  assign unused_wdata_mid = ^cfg_wdata[GB-1:ATTR_W];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              ld_lo, ld_hi;
    logic [HI_W-1:0]   base_d, lim_d;
    logic [ATTR_W-1:0] attr_d;
    logic              en_d;

    always_comb begin
      ld_lo  = cfg_we && !cfg_sel && (cfg_idx == IDX_W'(i));
      ld_hi  = cfg_we &&  cfg_sel && (cfg_idx == IDX_W'(i));
      base_d = cfg_wdata[AW-1:GB];
      attr_d = cfg_wdata[ATTR_W-1:0];
      lim_d  = cfg_wdata[AW-1:GB];
      en_d   = cfg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_hi[i] <= '0;
        attr[i]    <= '0;
      end else if (ld_lo) begin
        base_hi[i] <= base_d;
        attr[i]    <= attr_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lim_hi[i] <= '0;
        en[i]     <= 1'b0;
      end else if (ld_hi) begin
        lim_hi[i] <= lim_d;
        en[i]     <= en_d;
      end
    end

    a_r11_reset_disables: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !en[i]);
  end

endmodule

// File: rtl/bl_region_match.sv
module bl_region_match #(
  parameter int NREG  = 8,
  parameter int AW    = 32,
  parameter int GB    = 5,
  parameter int IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic [AW-GB-1:0]    base_hi [NREG],
  input  logic [AW-GB-1:0]    lim_hi  [NREG],
  input  logic [NREG-1:0]     en,
  output logic [NREG-1:0]     match,
  output logic                any_hit,
  output logic                multi_hit,
  output logic [IDX_W-1:0]    hit_idx
);

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    logic [AW-1:0] lo_addr, hi_addr;
    assign lo_addr  = {base_hi[i], {GB{1'b0}}};
    assign hi_addr  = {lim_hi[i], {GB{1'b1}}};
    assign match[i] = en[i] && (addr >= lo_addr) && (addr <= hi_addr);

    a_r2_off_region_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |-> !match[i]);
  end

  always_comb begin
    any_hit   = 1'b0;
    multi_hit = 1'b0;
    hit_idx   = '0;
    for (int i = 0; i < NREG; i++) begin
      if (match[i]) begin
        multi_hit = multi_hit | any_hit;
        any_hit   = 1'b1;
        hit_idx   = hit_idx | IDX_W'(i);
      end
    end
  end

  a_r4_multi_counts_two: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> ($countones(match) >= 2));
  a_r5_none_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (match == '0));

endmodule

// File: rtl/bl_perm_decode.sv
module bl_perm_decode
  import bl_prot_pkg::*;
(
  input  logic       use_default,
  input  logic       priv,
  input  logic       in_sys,
  input  logic [1:0] ap,
  input  logic       xn,
  output perm_t      perm
);

  logic rd_ok, wr_ok;

  always_comb begin
    if (use_default) begin
      rd_ok = 1'b1;
      wr_ok = 1'b1;
    end else begin
      rd_ok = priv | ap[0];
      wr_ok = (priv | ap[0]) & ~ap[1];
    end
    perm.r = rd_ok;
    perm.w = wr_ok;
    perm.x = (rd_ok | wr_ok) & ~in_sys & (use_default | ~xn);
  end

  always_comb begin
    if (in_sys) a_r7_sys_no_exec: assert (!perm.x);
  end

endmodule

// File: rtl/bl_prot_check.sv
module bl_prot_check
  import bl_prot_pkg::*;
#(
  parameter int              NREG      = 8,
  parameter int              AW        = 32,
  parameter int              GRAN_BITS = 5,
  parameter logic [AW-1:0]   SYS_BASE  = 32'hE000_0000,
  parameter logic [AW-1:0]   PPB_BASE  = 32'hE000_0000,
  parameter logic [AW-1:0]   PPB_LAST  = 32'hE00F_FFFF,
  localparam int             IDX_W     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             mpu_on,
  input  logic             bg_map_on,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_kind,
  input  logic             req_priv,
  output logic             rsp_valid,
  output logic             rsp_allow,
  output logic             rsp_fault,
  output logic [FST_W-1:0] rsp_status,
  output logic             rsp_perm_r,
  output logic             rsp_perm_w,
  output logic             rsp_perm_x
);

  localparam int HI_W   = AW - GRAN_BITS;
  localparam int ATTR_W = 3;

  logic [HI_W-1:0]   base_hi [NREG];
  logic [ATTR_W-1:0] attr    [NREG];
  logic [HI_W-1:0]   lim_hi  [NREG];
  logic [NREG-1:0]   en;

  bl_region_file #(
    .NREG(NREG), .AW(AW), .GB(GRAN_BITS), .ATTR_W(ATTR_W), .IDX_W(IDX_W)
  ) u_rf (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base_hi(base_hi), .attr(attr), .lim_hi(lim_hi), .en(en)
  );

  logic [NREG-1:0]  match;
  logic             any_hit, multi_hit;
  logic [IDX_W-1:0] hit_idx;

  bl_region_match #(
    .NREG(NREG), .AW(AW), .GB(GRAN_BITS), .IDX_W(IDX_W)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .addr(req_addr),
    .base_hi(base_hi), .lim_hi(lim_hi), .en(en),
    .match(match), .any_hit(any_hit), .multi_hit(multi_hit), .hit_idx(hit_idx)
  );

  // Default-map conditions and address windows
  logic in_sys, in_ppb, use_default;
  logic [ATTR_W-1:0] sel_attr;

  always_comb begin
    in_sys      = req_addr >= SYS_BASE;
    in_ppb      = (req_addr >= PPB_BASE) && (req_addr <= PPB_LAST);
    use_default = !mpu_on || in_ppb || (bg_map_on && req_priv);
    sel_attr    = attr[hit_idx];
  end

  perm_t granted;

  bl_perm_decode u_dec (
    .use_default(use_default), .priv(req_priv), .in_sys(in_sys),
    .ap(sel_attr[2:1]), .xn(sel_attr[0]), .perm(granted)
  );

  // Verdict, next-state
  logic             kind_ok;
  logic             allow_d;
  logic [FST_W-1:0] status_d;
  perm_t            perm_d;

  always_comb begin
    unique case (acc_kind_e'(req_kind))
      ACC_RD:  kind_ok = granted.r;
      ACC_WR:  kind_ok = granted.w;
      ACC_FX:  kind_ok = granted.x;
      default: kind_ok = 1'b0;
    endcase

    if (!use_default && multi_hit) begin
      allow_d  = 1'b0;
      status_d = FST_PERM;
      perm_d   = '0;
    end else if (!use_default && !any_hit) begin
      allow_d  = 1'b0;
      status_d = FST_BG;
      perm_d   = '0;
    end else if (!kind_ok) begin
      allow_d  = 1'b0;
      status_d = FST_PERM;
      perm_d   = granted;
    end else begin
      allow_d  = 1'b1;
      status_d = FST_OK;
      perm_d   = granted;
    end
  end

  // Response registers
  logic             allow_q, fault_q;
  logic [FST_W-1:0] status_q;
  perm_t            perm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_q  <= 1'b0;
      fault_q  <= 1'b0;
      status_q <= '0;
      perm_q   <= '0;
    end else if (req_valid) begin
      allow_q  <= allow_d;
      fault_q  <= !allow_d;
      status_q <= status_d;
      perm_q   <= perm_d;
    end
  end

  assign rsp_allow  = allow_q;
  assign rsp_fault  = fault_q;
  assign rsp_status = status_q;
  assign rsp_perm_r = perm_q.r;
  assign rsp_perm_w = perm_q.w;
  assign rsp_perm_x = perm_q.x;

  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_no_req_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_allow) && $stable(rsp_status)));
  a_r11_allow_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_allow != rsp_fault));
  a_r8_exec_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perm_x |-> rsp_perm_r);
  a_r7_sys_response_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ($past(req_addr) >= SYS_BASE)) |-> !rsp_perm_x);
  a_r5_bg_fault_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && rsp_status == FST_BG) |-> !(rsp_perm_r || rsp_perm_w || rsp_perm_x));
  a_r9_allow_has_perm: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_allow |-> (rsp_perm_r || rsp_perm_w || rsp_perm_x));

endmodule

// File: tb/bl_prot_check_test.sv
`timescale 1ns/1ps
module bl_prot_check_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        mpu_on, bg_map_on;
  logic        req_valid, req_priv;
  logic [31:0] req_addr;
  logic [1:0]  req_kind;
  logic        rsp_valid, rsp_allow, rsp_fault;
  logic [7:0]  rsp_status;
  logic        rsp_perm_r, rsp_perm_w, rsp_perm_x;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  bl_prot_check uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mpu_on(mpu_on), .bg_map_on(bg_map_on),
    .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
    .rsp_status(rsp_status), .rsp_perm_r(rsp_perm_r), .rsp_perm_w(rsp_perm_w),
    .rsp_perm_x(rsp_perm_x)
  );

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, FX = 2'b10, RSV = 2'b11;

  function automatic logic [13:0] outs();
    return {rsp_valid, rsp_allow, rsp_fault, rsp_status, rsp_perm_r, rsp_perm_w, rsp_perm_x};
  endfunction

  task automatic chk(input string tag, input logic [13:0] got, input logic [13:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got v/a/f/st/rwx=%h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_region(input int idx, input logic [31:0] lo, input logic [31:0] hi);
    cfg_write(idx, 1'b0, lo);
    cfg_write(idx, 1'b1, hi);
  endtask

  task automatic access(input string tag, input logic [31:0] a, input logic [1:0] k,
                        input logic p, input logic ea, input logic [7:0] es,
                        input logic [2:0] erwx);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; req_priv = p;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, outs(), {1'b1, ea, !ea, es, erwx});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cfg_we = 0; cfg_idx = 0; cfg_sel = 0; cfg_wdata = 0;
    mpu_on = 0; bg_map_on = 0;
    req_valid = 0; req_addr = 0; req_kind = 0; req_priv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 outputs after reset", outs(), 14'h0);
    mpu_on = 1'b1;
    access("R11 regions disabled after reset", 32'h2000_0000, RD, 1, 0, 8'h00, 3'b000);
    access("R5 no region background fault", 32'h0000_0040, WR, 0, 0, 8'h00, 3'b000);
  endtask

  task automatic t_mpu_off();
    mpu_on = 1'b0;
    access("R6 protection off user fetch", 32'h1000_0000, FX, 0, 1, 8'h00, 3'b111);
    access("R7 protection off sys fetch", 32'hF000_0000, FX, 0, 0, 8'h0D, 3'b110);
    access("R6 protection off sys write", 32'hF000_0000, WR, 0, 1, 8'h00, 3'b110);
    mpu_on = 1'b1;
  endtask

  task automatic t_region_bounds();
    set_region(0, 32'h2000_001A, 32'h2000_0FE1);
    access("R1 lower bound low bits ignored", 32'h2000_0000, RD, 0, 1, 8'h00, 3'b111);
    access("R1 upper bound inclusive", 32'h2000_0FFF, WR, 0, 1, 8'h00, 3'b111);
    access("R1 just above upper bound", 32'h2000_1000, RD, 1, 0, 8'h00, 3'b000);
    access("R1 just below lower bound", 32'h1FFF_FFFF, RD, 1, 0, 8'h00, 3'b000);
    access("R8 fetch allowed xn clear", 32'h2000_0800, FX, 0, 1, 8'h00, 3'b111);
  endtask

  task automatic t_enable_bit();
    cfg_write(0, 1'b1, 32'h2000_0FE0);
    access("R2 disabled region ignored", 32'h2000_0000, RD, 1, 0, 8'h00, 3'b000);
    cfg_write(0, 1'b1, 32'h2000_0FE1);
    access("R2 region re-enabled", 32'h2000_0000, RD, 1, 1, 8'h00, 3'b111);
  endtask

  task automatic t_ap_decode();
    set_region(1, 32'h3000_0000, 32'h3000_00E1);
    access("R3 code 00 priv write", 32'h3000_0010, WR, 1, 1, 8'h00, 3'b111);
    access("R3 code 00 user read", 32'h3000_0010, RD, 0, 0, 8'h0D, 3'b000);
    cfg_write(1, 1'b0, 32'h3000_0004);
    access("R3 code 10 priv read", 32'h3000_0020, RD, 1, 1, 8'h00, 3'b101);
    access("R3 code 10 priv write", 32'h3000_0020, WR, 1, 0, 8'h0D, 3'b101);
    access("R3 code 10 user read", 32'h3000_0020, RD, 0, 0, 8'h0D, 3'b000);
    cfg_write(1, 1'b0, 32'h3000_0006);
    access("R3 code 11 user read", 32'h3000_00FF, RD, 0, 1, 8'h00, 3'b101);
    access("R3 code 11 user write", 32'h3000_00FF, WR, 0, 0, 8'h0D, 3'b101);
    cfg_write(1, 1'b0, 32'h3000_0003);
    access("R8 execute-never fetch", 32'h3000_0040, FX, 0, 0, 8'h0D, 3'b110);
    access("R3 code 01 user write", 32'h3000_0040, WR, 0, 1, 8'h00, 3'b110);
  endtask

  task automatic t_overlap();
    set_region(2, 32'h2000_0802, 32'h2000_1FE1);
    access("R4 two regions match", 32'h2000_0900, RD, 1, 0, 8'h0D, 3'b000);
    access("R4 only second region", 32'h2000_1800, RD, 0, 1, 8'h00, 3'b111);
    access("R4 only first region", 32'h2000_0100, RD, 0, 1, 8'h00, 3'b111);
    bg_map_on = 1'b1;
    access("R6 privileged default map skips overlap", 32'h2000_0900, RD, 1, 1, 8'h00, 3'b111);
    access("R4 user overlap with default map on", 32'h2000_0900, RD, 0, 0, 8'h0D, 3'b000);
    bg_map_on = 1'b0;
  endtask

  task automatic t_ppb_sys();
    access("R6 peripheral window user write", 32'hE000_1000, WR, 0, 1, 8'h00, 3'b110);
    access("R7 peripheral window fetch", 32'hE000_1000, FX, 0, 0, 8'h0D, 3'b110);
    access("R6 above peripheral window no region", 32'hE010_0000, RD, 0, 0, 8'h00, 3'b000);
    set_region(3, 32'hE010_0002, 32'hE010_0FE1);
    access("R7 sys region xn clear fetch", 32'hE010_0000, FX, 0, 0, 8'h0D, 3'b110);
    access("R7 sys region read", 32'hE010_0000, RD, 0, 1, 8'h00, 3'b110);
  endtask

  task automatic t_bg_map();
    bg_map_on = 1'b1;
    access("R6 default map privileged fetch", 32'h4000_0000, FX, 1, 1, 8'h00, 3'b111);
    access("R6 default map user not covered", 32'h4000_0000, RD, 0, 0, 8'h00, 3'b000);
  endtask

  task automatic t_reserved_kind();
    access("R9 reserved kind unmapped user", 32'h4000_0000, RSV, 0, 0, 8'h00, 3'b000);
    bg_map_on = 1'b0;
    mpu_on = 1'b0;
    access("R9 reserved kind default map", 32'h1000_0000, RSV, 1, 0, 8'h0D, 3'b111);
    mpu_on = 1'b1;
    access("R9 reserved kind in region", 32'h2000_0100, RSV, 0, 0, 8'h0D, 3'b111);
  endtask

  task automatic t_timing();
    set_region(4, 32'h5000_0002, 32'h5000_0FE0);
    access("R10 allowed response", 32'h2000_0100, RD, 0, 1, 8'h00, 3'b111);
    @(negedge clk);
    chk("R10 idle cycle holds verdict", outs(), {1'b0, 1'b1, 1'b0, 8'h00, 3'b111});
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd4; cfg_sel = 1'b1; cfg_wdata = 32'h5000_0FE1;
    req_valid = 1'b1; req_addr = 32'h5000_0000; req_kind = RD; req_priv = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R10 same-cycle write not yet seen", outs(), {1'b1, 1'b0, 1'b1, 8'h00, 3'b000});
    access("R10 write seen next request", 32'h5000_0000, RD, 0, 1, 8'h00, 3'b111);
  endtask

  initial begin
    t_reset();
    t_mpu_off();
    t_region_bounds();
    t_enable_bit();
    t_ap_decode();
    t_overlap();
    t_ppb_sys();
    t_bg_map();
    t_reserved_kind();
    t_timing();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule